// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a word-wide flash device. A host writes single command bytes on a strobed bus; the block decodes them and chooses what a read returns (array data, status, configuration or query data). It also runs the multi-write sequences for word program, block erase and block locking, and it handles suspend and resume of a running program or erase.

The operation itself is stubbed as a busy counter. The host supplies three condition inputs. The first says that the targeted block is locked. The second says that the programming supply is too low. The third says that the running operation failed. The block keeps an 8-bit status word. In that word, bit 7 is ready, bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 3 is supply error, bit 2 is program suspended, bit 1 is locked-target abort, and bit 0 always reads 0. The error bits are sticky until the host clears them.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, the status word is 80h and the read mode is array. The rd_mode encoding is: 0 = array, 1 = status, 2 = configuration, 3 = query.
- R2: While idle, the following bytes select the read mode without starting an operation: FFh selects array, 70h selects status, 90h selects configuration and 98h selects query.
- R3: A program setup byte (40h or 10h) is followed by a data write, which starts a program. Status bit 7 stays 0 for P_CYCLES cycles. The block then returns to ready in status mode.
- R4: An erase setup byte (20h) followed by D0h starts an erase that runs for E_CYCLES cycles. Any other second byte sets status bits 4 and 5 and starts nothing.
- R5: Status bits 1, 3, 4 and 5 are cleared only by the clear-status byte 50h. Writing FFh leaves them set.
- R6: While status bit 3 is set, a program or erase confirm is refused. Status bit 7 stays 1 and no new error bit is set.
- R7: A confirm with tgt_locked high aborts the operation and sets bit 1. A confirm with supply_low high sets bit 3, plus bit 4 for a program or bit 5 for an erase. A program that ends with op_fail high sets bit 4. An erase that ends with op_fail high sets bit 5.
- R8: B0h during an erase suspends it. Bit 6 and bit 7 then read 1. While suspended, the block accepts the read-mode bytes, a program sequence and a lock sequence. D0h resumes the erase.
- R9: B0h during a program suspends it. Bit 2 and bit 7 then read 1. Only the read-mode bytes and D0h (resume) are accepted; any other byte is ignored.
- R10: A lock setup byte (60h) followed by 01h, D0h or 2Fh completes a lock command in status mode. Any other second byte sets bits 4 and 5.
- R11: A program setup, erase setup or lock setup byte, and the end of any operation, leave the read mode at status.
- R12: Bits 6 and 2 are never 1 at the same time. Each one clears when its operation resumes or completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command/data byte strobe, one cycle per write |
| cmd_byte | input | 8 | Written byte |
| tgt_locked | input | 1 | Target of the confirm write lies in a locked block |
| supply_low | input | 1 | Programming supply out of range at confirm |
| op_fail | input | 1 | Running operation fails when it ends |
| rd_mode | output | 2 | Selected read source |
| status | output | 8 | Status word |

## Verification
The assertions assume that cmd_valid lasts one clock for each write and that cmd_byte is stable while it is high. They also assume that the three condition inputs change only between writes, never across a confirm edge. The bench meets these conditions by driving every input on the falling edge and holding each write for exactly one cycle. It sets the condition inputs before the write sequence they qualify begins, and keeps op_fail high for the whole run of a failing operation.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int P_CYCLES = 8,
  parameter int E_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       tgt_locked,
  input  logic       supply_low,
  input  logic       op_fail,
  output logic [1:0] rd_mode,
  output logic [7:0] status
);
  localparam int MAXC = (P_CYCLES > E_CYCLES) ? P_CYCLES : E_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PC = CW'(P_CYCLES);
  localparam logic [CW-1:0] EC = CW'(E_CYCLES);

  localparam logic [1:0] M_ARR = 2'd0, M_STS = 2'd1, M_CFG = 2'd2, M_QRY = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PSET, S_ESET, S_LSET, S_PROG, S_ERS,
    S_PSUS, S_ESUS, S_EPSET, S_EPROG, S_ELSET
  } st_t;

  st_t st;
  logic [1:0] mode;
  logic e1, e3, e4, e5;
  logic [CW-1:0] pcnt, ecnt;

  logic is_rd;
  logic [1:0] rd_code;
  logic lock_ok;
  logic idle;

  always_comb begin
    is_rd = 1'b1;
    rd_code = M_ARR;
    case (cmd_byte)
      8'hFF: rd_code = M_ARR;
      8'h70: rd_code = M_STS;
      8'h90: rd_code = M_CFG;
      8'h98: rd_code = M_QRY;
      default: is_rd = 1'b0;
    endcase
  end

  assign lock_ok = (cmd_byte == 8'h01) || (cmd_byte == 8'hD0) || (cmd_byte == 8'h2F);
  assign idle = (st == S_IDLE);

  assign rd_mode = mode;
  assign status = {
    !(st == S_PROG || st == S_ERS || st == S_EPROG),
    (st == S_ESUS || st == S_EPSET || st == S_EPROG || st == S_ELSET),
    e5, e4, e3,
    (st == S_PSUS),
    e1, 1'b0
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode <= M_ARR;
      e1 <= 1'b0;
      e3 <= 1'b0;
      e4 <= 1'b0;
      e5 <= 1'b0;
      pcnt <= '0;
      ecnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (is_rd) mode <= rd_code;
          else case (cmd_byte)
            8'h50: begin e1 <= 1'b0; e3 <= 1'b0; e4 <= 1'b0; e5 <= 1'b0; end
            8'h40, 8'h10: begin st <= S_PSET; mode <= M_STS; end
            8'h20: begin st <= S_ESET; mode <= M_STS; end
            8'h60: begin st <= S_LSET; mode <= M_STS; end
            default: ;
          endcase
        end

        S_PSET, S_EPSET: if (cmd_valid) begin
          mode <= M_STS;
          st <= (st == S_PSET) ? S_IDLE : S_ESUS;
          if (e3) ;
          else if (supply_low) begin e3 <= 1'b1; e4 <= 1'b1; end
          else if (tgt_locked) e1 <= 1'b1;
          else begin
            st <= (st == S_PSET) ? S_PROG : S_EPROG;
            pcnt <= PC;
          end
        end

        S_ESET: if (cmd_valid) begin
          mode <= M_STS;
          st <= S_IDLE;
          if (cmd_byte != 8'hD0) begin e4 <= 1'b1; e5 <= 1'b1; end
          else if (e3) ;
          else if (supply_low) begin e3 <= 1'b1; e5 <= 1'b1; end
          else if (tgt_locked) e1 <= 1'b1;
          else begin st <= S_ERS; ecnt <= EC; end
        end

        S_LSET, S_ELSET: if (cmd_valid) begin
          mode <= M_STS;
          st <= (st == S_LSET) ? S_IDLE : S_ESUS;
          if (!lock_ok) begin e4 <= 1'b1; e5 <= 1'b1; end
        end

        S_PROG, S_EPROG: begin
          if (pcnt <= 1) begin
            st <= (st == S_PROG) ? S_IDLE : S_ESUS;
            mode <= M_STS;
            if (op_fail) e4 <= 1'b1;
          end else begin
            pcnt <= pcnt - 1'b1;
            if (st == S_PROG && cmd_valid && cmd_byte == 8'hB0) begin
              st <= S_PSUS;
              mode <= M_STS;
            end
          end
        end

        S_ERS: begin
          if (ecnt <= 1) begin
            st <= S_IDLE;
            mode <= M_STS;
            if (op_fail) e5 <= 1'b1;
          end else begin
            ecnt <= ecnt - 1'b1;
            if (cmd_valid && cmd_byte == 8'hB0) begin
              st <= S_ESUS;
              mode <= M_STS;
            end
          end
        end

        S_PSUS: if (cmd_valid) begin
          if (is_rd) mode <= rd_code;
          else if (cmd_byte == 8'hD0) begin st <= S_PROG; mode <= M_STS; end
        end

        S_ESUS: if (cmd_valid) begin
          if (is_rd) mode <= rd_code;
          else case (cmd_byte)
            8'h40, 8'h10: begin st <= S_EPSET; mode <= M_STS; end
            8'h60: begin st <= S_ELSET; mode <= M_STS; end
            8'hD0: begin st <= S_ERS; mode <= M_STS; end
            default: ;
          endcase
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       idle,
  input logic [1:0] rd_mode,
  input logic [7:0] status
);
  a_r5_sticky_b1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(cmd_valid && cmd_byte == 8'h50));
  a_r5_sticky_b3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> $past(cmd_valid && cmd_byte == 8'h50));
  a_r5_sticky_b4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(cmd_valid && cmd_byte == 8'h50));
  a_r5_sticky_b5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(cmd_valid && cmd_byte == 8'h50));
  a_r12_susp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[2]));
  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && status[7] && !status[6] && !status[2]) |=> status[7]);
  a_r2_ff_array: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_valid && cmd_byte == 8'hFF) |=> rd_mode == 2'd0);
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .idle(idle), .rd_mode(rd_mode), .status(status)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic tgt_locked = 1'b0, supply_low = 1'b0, op_fail = 1'b0;
  logic [1:0] rd_mode;
  logic [7:0] status;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_fsm #(.P_CYCLES(8), .E_CYCLES(16)) u_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .tgt_locked(tgt_locked), .supply_low(supply_low), .op_fail(op_fail),
    .rd_mode(rd_mode), .status(status));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic idle_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 8'h80);
    chk("R1 mode", {6'd0, rd_mode}, 8'd0);
  endtask

  task automatic t_read_modes;
    wr(8'h70); chk("R2 status mode", {6'd0, rd_mode}, 8'd1);
    wr(8'h90); chk("R2 config mode", {6'd0, rd_mode}, 8'd2);
    wr(8'h98); chk("R2 query mode", {6'd0, rd_mode}, 8'd3);
    wr(8'hFF); chk("R2 array mode", {6'd0, rd_mode}, 8'd0);
    chk("R2 no op started", status, 8'h80);
  endtask

  task automatic t_program;
    wr(8'h40); chk("R11 setup status mode", {6'd0, rd_mode}, 8'd1);
    wr(8'h5A); chk("R3 busy", status, 8'h00);
    idle_n(6); chk("R3 still busy", status, 8'h00);
    idle_n(3); chk("R3 done", status, 8'h80);
    chk("R11 done status mode", {6'd0, rd_mode}, 8'd1);
  endtask

  task automatic t_erase_seq_err;
    wr(8'h20); wr(8'h33);
    chk("R4 sequence error", status, 8'hB0);
    wr(8'hFF); chk("R5 FF keeps bits", status, 8'hB0);
    chk("R2 FF from error", {6'd0, rd_mode}, 8'd0);
    wr(8'h50); chk("R5 clear", status, 8'h80);
    wr(8'h20); wr(8'hD0); chk("R4 erase busy", status, 8'h00);
    idle_n(14); chk("R4 erase still busy", status, 8'h00);
    idle_n(3); chk("R4 erase done", status, 8'h80);
  endtask

  task automatic t_errors;
    tgt_locked = 1'b1;
    wr(8'h40); wr(8'h11); chk("R7 locked abort", status, 8'h82);
    tgt_locked = 1'b0;
    wr(8'h50); chk("R5 clear b1", status, 8'h80);
    supply_low = 1'b1;
    wr(8'h10); wr(8'h11); chk("R7 supply low prog", status, 8'h98);
    supply_low = 1'b0;
    wr(8'h20); wr(8'hD0); chk("R6 refused erase", status, 8'h98);
    wr(8'h40); wr(8'h22); chk("R6 refused prog", status, 8'h98);
    wr(8'h50); chk("R5 clear b3", status, 8'h80);
    op_fail = 1'b1;
    wr(8'h40); wr(8'h22); idle_n(10);
    chk("R7 program fail", status, 8'h90);
    wr(8'h50);
    wr(8'h20); wr(8'hD0); idle_n(18);
    chk("R7 erase fail", status, 8'hA0);
    op_fail = 1'b0;
    wr(8'h50); chk("R5 clear b5", status, 8'h80);
  endtask

  task automatic t_erase_suspend;
    wr(8'h20); wr(8'hD0); idle_n(2);
    wr(8'hB0); chk("R8 suspended", status, 8'hC0);
    wr(8'hFF); chk("R8 read array in susp", {6'd0, rd_mode}, 8'd0);
    wr(8'h40); wr(8'h77); chk("R8 program in susp busy", status, 8'h40);
    idle_n(10); chk("R8 program in susp done", status, 8'hC0);
    wr(8'h60); wr(8'h01); chk("R8 lock in susp", status, 8'hC0);
    chk("R11 lock leaves status mode", {6'd0, rd_mode}, 8'd1);
    wr(8'hD0); chk("R12 resume clears b6", status, 8'h00);
    idle_n(20); chk("R8 erase finishes", status, 8'h80);
  endtask

  task automatic t_prog_suspend;
    wr(8'h40); wr(8'h12);
    wr(8'hB0); chk("R9 suspended", status, 8'h84);
    wr(8'h20); chk("R9 erase setup ignored", status, 8'h84);
    wr(8'h90); chk("R9 read config", {6'd0, rd_mode}, 8'd2);
    wr(8'hD0); chk("R12 resume clears b2", status, 8'h00);
    idle_n(10); chk("R9 program finishes", status, 8'h80);
  endtask

  task automatic t_lock;
    wr(8'h60); wr(8'h2F); chk("R10 lockdown ok", status, 8'h80);
    chk("R10 status mode", {6'd0, rd_mode}, 8'd1);
    wr(8'h60); wr(8'h44); chk("R10 bad confirm", status, 8'hB0);
    wr(8'h50); chk("R10 cleared", status, 8'h80);
  endtask

  initial begin
    idle_n(3);
    rst_n = 1'b1;
    idle_n(1);
    t_reset();
    t_read_modes();
    t_program();
    t_erase_seq_err();
    t_errors();
    t_erase_suspend();
    t_prog_suspend();
    t_lock();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule